// File: doc/BRIEF.md
# Sequential Integer Divider with Condition Flags

This block divides integers one quotient bit per clock. It serves an execution unit that already has the operand registers read out. A single start cycle hands over the dividend and the divisor, the register indices that will receive the results, and the current N, Z and V flags. The block then works through a restoring shift-subtract loop over operand magnitudes and applies the signs at the end. When it finishes, it raises a one-cycle done strobe. In that same cycle it presents the new flags, a divide-by-zero indication, and up to two register write ports, each with its own enable.

Three operand sizes are supported, each signed or unsigned. The first is a 32-bit dividend over a 16-bit divisor, which packs both results into a single register. The second is 32 over 32. The third is a 64-bit dividend over a 32-bit divisor, where the dividend's upper half comes from the remainder register and its lower half from the quotient register. The block decides which write ports fire when the quotient and remainder registers coincide, and a build option selects the reduced instruction-set rule for the 32/32 case. Raising a trap on a zero divisor belongs to the surrounding core. This block only reports the condition.

Top module: `int_div_cc`

## Requirements
- R1: In every done cycle the carry output c_o is 0, including overflow and zero-divisor results.
- R2: If the divisor is zero, the result is dz_o=1 with both write enables low, and N/Z/V equal to the n_i/z_i/v_i values captured at start. Done follows one cycle after the start edge. In 16-bit-divisor mode only dvs_i[15:0] is examined.
- R3: In word mode (size_i=00), an unsigned divide overflows when the quotient is above 0xFFFF. A signed divide overflows when the quotient lies outside -32768..32767.
- R4: On overflow, V=1, Z=0, N equals the n_i captured at start, and neither write enable is raised.
- R5: A successful word-mode divide raises only qwe_o. The value qdat_o={remainder[15:0], quotient[15:0]} goes to qsel_o. N is quotient bit 15, Z means the 16-bit quotient is zero, and V=0.
- R6: In 64/32 mode (size_i=1x), the dividend is {dr_i, dq_i}. The divide overflows when the quotient does not fit in 32 bits (unsigned range, or signed range when signed_i=1).
- R7: A successful long divide (size_i=01 or 1x) in the default build writes the quotient to qsel_o and raises rwe_o for the remainder only when rsel_o differs from qsel_o, so the quotient wins.
- R8: With REDUCED=1 and size_i=01, equal indices raise only qwe_o with the quotient. Different indices raise only rwe_o with the remainder.
- R9: After a successful long divide, N is quotient bit 31, Z means the 32-bit quotient is zero, and V=0.
- R10: Signed division truncates toward zero and the remainder carries the dividend's sign. In word mode the divisor is dvs_i[15:0], sign- or zero-extended. In 32/32 mode the dividend is dq_i, extended by signedness, and the most negative value divided by -1 overflows.
- R11: A start is accepted only while busy_o is 0. done_o pulses for one cycle, 33 cycles after the accepting edge (65 in 64/32 mode). busy_o stays high until then, and a start raised while busy is ignored.
- R12: After reset, busy_o, done_o, qwe_o and rwe_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| size_i | input | 2 | 00 word 32/16, 01 long 32/32, 1x long 64/32 |
| signed_i | input | 1 | Signed operation |
| dq_i | input | DW | Quotient register contents (dividend, low half) |
| dr_i | input | DW | Remainder register contents (dividend high half in 64/32) |
| dvs_i | input | DW | Divisor |
| qsel_i | input | RW | Quotient register index |
| rsel_i | input | RW | Remainder register index |
| n_i | input | 1 | Current N flag |
| z_i | input | 1 | Current Z flag |
| v_i | input | 1 | Current V flag |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle completion strobe |
| dz_o | output | 1 | Divisor was zero |
| n_o | output | 1 | Result N flag |
| z_o | output | 1 | Result Z flag |
| v_o | output | 1 | Result V flag |
| c_o | output | 1 | Result C flag |
| qwe_o | output | 1 | Quotient port write enable |
| qsel_o | output | RW | Quotient port register index |
| qdat_o | output | DW | Quotient port data |
| rwe_o | output | 1 | Remainder port write enable |
| rsel_o | output | RW | Remainder port register index |
| rdat_o | output | DW | Remainder port data |

## Verification
The assertions assume that start_i and the operands are sampled only on the edge where the block is idle. They also assume that the core consumes the write ports only while done_o is high. The bench drives every input half a cycle away from the active edge. It scrambles the operands right after each accepted start and also raises start once in the middle of a divide, so the assertions see inputs that change freely while the block is busy. Two instances, one for each REDUCED setting, receive the same stimulus.

// File: rtl/int_div_cc.sv
module int_div_cc #(
  parameter int DW = 32,
  parameter int RW = 3,
  parameter bit REDUCED = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    size_i,
  input  logic          signed_i,
  input  logic [DW-1:0] dq_i,
  input  logic [DW-1:0] dr_i,
  input  logic [DW-1:0] dvs_i,
  input  logic [RW-1:0] qsel_i,
  input  logic [RW-1:0] rsel_i,
  input  logic          n_i,
  input  logic          z_i,
  input  logic          v_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          dz_o,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o,
  output logic          c_o,
  output logic          qwe_o,
  output logic [RW-1:0] qsel_o,
  output logic [DW-1:0] qdat_o,
  output logic          rwe_o,
  output logic [RW-1:0] rsel_o,
  output logic [DW-1:0] rdat_o
);
  localparam int HW = DW / 2;
  localparam int XW = 2 * DW;
  localparam int CW = $clog2(XW + 1);
  localparam logic [XW-1:0] ONE = XW'(1);
  localparam logic [CW-1:0] ITER_S = CW'(DW);
  localparam logic [CW-1:0] ITER_X = CW'(XW);

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;
  st_t st;

  logic [XW-1:0] quo;
  logic [DW-1:0] rem, dvs;
  logic [CW-1:0] cnt;
  logic [1:0]    sz;
  logic          sgn, qneg, rneg, zdiv, n_h, z_h, v_h;
  logic [RW-1:0] qs, rs;

  logic [XW-1:0] a_ext, a_mag, a_aln;
  logic [DW-1:0] d_ext, d_mag;
  logic          a_neg, d_neg;

  always_comb begin
    if (size_i[1]) a_ext = {dr_i, dq_i};
    else           a_ext = {{DW{signed_i & dq_i[DW-1]}}, dq_i};
    a_neg = signed_i & a_ext[XW-1];
    a_mag = a_neg ? -a_ext : a_ext;
    a_aln = size_i[1] ? a_mag : {a_mag[DW-1:0], {DW{1'b0}}};
    if (size_i == 2'b00) d_ext = {{HW{signed_i & dvs_i[HW-1]}}, dvs_i[HW-1:0]};
    else                 d_ext = dvs_i;
    d_neg = signed_i & d_ext[DW-1];
    d_mag = d_neg ? -d_ext : d_ext;
  end

  logic [DW+1:0] diff;
  logic          ge;
  assign diff = {1'b0, rem, quo[XW-1]} - {2'b00, dvs};
  assign ge   = ~diff[DW+1];

  logic [XW-1:0] q_s, half, lim;
  logic [DW-1:0] r_s;
  logic          ovf, wmode;
  assign wmode = (sz == 2'b00);
  assign q_s   = qneg ? -quo : quo;
  assign r_s   = rneg ? -rem : rem;
  assign half  = wmode ? (ONE << (HW - 1)) : (ONE << (DW - 1));
  assign lim   = !sgn ? ((half << 1) - ONE) : (qneg ? half : half - ONE);
  assign ovf   = quo > lim;

  assign busy_o = (st != IDLE);
  assign qsel_o = qs;
  assign rsel_o = rs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= IDLE;
      quo <= '0; rem <= '0; dvs <= '0; cnt <= '0;
      sz <= '0; sgn <= 1'b0; qneg <= 1'b0; rneg <= 1'b0; zdiv <= 1'b0;
      n_h <= 1'b0; z_h <= 1'b0; v_h <= 1'b0; qs <= '0; rs <= '0;
      done_o <= 1'b0; dz_o <= 1'b0; n_o <= 1'b0; z_o <= 1'b0; v_o <= 1'b0; c_o <= 1'b0;
      qwe_o <= 1'b0; rwe_o <= 1'b0; qdat_o <= '0; rdat_o <= '0;
    end else begin
      done_o <= 1'b0;
      qwe_o  <= 1'b0;
      rwe_o  <= 1'b0;
      unique case (st)
        IDLE: if (start_i) begin
          sz <= size_i; sgn <= signed_i; qs <= qsel_i; rs <= rsel_i;
          n_h <= n_i; z_h <= z_i; v_h <= v_i;
          qneg <= a_neg ^ d_neg;
          rneg <= a_neg;
          dvs  <= d_mag;
          quo  <= a_aln;
          rem  <= '0;
          cnt  <= size_i[1] ? ITER_X : ITER_S;
          zdiv <= (d_ext == '0);
          st   <= (d_ext == '0) ? FIN : RUN;
        end
        RUN: begin
          rem <= ge ? diff[DW-1:0] : {rem[DW-2:0], quo[XW-1]};
          quo <= {quo[XW-2:0], ge};
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) st <= FIN;
        end
        FIN: begin
          st     <= IDLE;
          done_o <= 1'b1;
          c_o    <= 1'b0;
          dz_o   <= zdiv;
          if (zdiv) begin
            n_o <= n_h; z_o <= z_h; v_o <= v_h;
          end else if (ovf) begin
            n_o <= n_h; z_o <= 1'b0; v_o <= 1'b1;
          end else if (wmode) begin
            n_o    <= q_s[HW-1];
            z_o    <= (q_s[HW-1:0] == '0);
            v_o    <= 1'b0;
            qdat_o <= {r_s[HW-1:0], q_s[HW-1:0]};
            qwe_o  <= 1'b1;
          end else begin
            n_o    <= q_s[DW-1];
            z_o    <= (q_s[DW-1:0] == '0);
            v_o    <= 1'b0;
            qdat_o <= q_s[DW-1:0];
            rdat_o <= r_s;
            if (REDUCED && sz == 2'b01) begin
              qwe_o <= (qs == rs);
              rwe_o <= (qs != rs);
            end else begin
              qwe_o <= 1'b1;
              rwe_o <= (qs != rs);
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_div_cc_chk.sv
module int_div_cc_chk #(
  parameter int RW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          dz_o,
  input logic          z_o,
  input logic          v_o,
  input logic          qwe_o,
  input logic          rwe_o,
  input logic [RW-1:0] qsel_o,
  input logic [RW-1:0] rsel_o
);
  assert_dz_nowrite_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && dz_o |-> !qwe_o && !rwe_o);

  assert_ovf_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !dz_o && v_o |-> !z_o && !qwe_o && !rwe_o);

  assert_quot_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qwe_o && rwe_o |-> qsel_o != rsel_o);

  assert_we_in_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qwe_o || rwe_o) |-> done_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind int_div_cc int_div_cc_chk #(.RW(RW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o), .dz_o(dz_o),
  .z_o(z_o), .v_o(v_o), .qwe_o(qwe_o), .rwe_o(rwe_o), .qsel_o(qsel_o), .rsel_o(rsel_o)
);

// File: tb/int_div_cc_tb_top.sv
`timescale 1ns/1ps
module int_div_cc_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic start = 1'b0, sg = 1'b0, nin = 1'b0, zin = 1'b0, vin = 1'b0;
  logic [1:0] size = 2'b00;
  logic [31:0] dq = '0, dr = '0, dv = '0;
  logic [2:0] qs = '0, rs = '0;

  logic busy[2], done[2], dz[2], fn[2], fz[2], fv[2], fc[2], qwe[2], rwe[2];
  logic [2:0] qso[2], rso[2];
  logic [31:0] qdat[2], rdat[2];

  int_div_cc #(.DW(32), .RW(3), .REDUCED(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .signed_i(sg),
    .dq_i(dq), .dr_i(dr), .dvs_i(dv), .qsel_i(qs), .rsel_i(rs), .n_i(nin), .z_i(zin), .v_i(vin),
    .busy_o(busy[0]), .done_o(done[0]), .dz_o(dz[0]), .n_o(fn[0]), .z_o(fz[0]), .v_o(fv[0]),
    .c_o(fc[0]), .qwe_o(qwe[0]), .qsel_o(qso[0]), .qdat_o(qdat[0]), .rwe_o(rwe[0]),
    .rsel_o(rso[0]), .rdat_o(rdat[0]));

  int_div_cc #(.DW(32), .RW(3), .REDUCED(1'b1)) dut_red_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .signed_i(sg),
    .dq_i(dq), .dr_i(dr), .dvs_i(dv), .qsel_i(qs), .rsel_i(rs), .n_i(nin), .z_i(zin), .v_i(vin),
    .busy_o(busy[1]), .done_o(done[1]), .dz_o(dz[1]), .n_o(fn[1]), .z_o(fz[1]), .v_o(fv[1]),
    .c_o(fc[1]), .qwe_o(qwe[1]), .qsel_o(qso[1]), .qdat_o(qdat[1]), .rwe_o(rwe[1]),
    .rsel_o(rso[1]), .rdat_o(rdat[1]));

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model
  bit m_busy = 0, m_done = 0;
  int m_left = 0;
  bit e_dz, e_n, e_z, e_v;
  bit e_qwe[2], e_rwe[2];
  logic [2:0] e_qs, e_rs;
  logic [31:0] e_qdat, e_rdat;
  string t_flag, t_wr[2], t_dat;

  task automatic model_start();
    logic signed [66:0] num, den, q, r;
    bit ovf;
    e_qs = qs; e_rs = rs;
    for (int i = 0; i < 2; i++) begin e_qwe[i] = 0; e_rwe[i] = 0; end
    if (size[1]) num = sg ? {{3{dr[31]}}, dr, dq} : {3'b0, dr, dq};
    else         num = sg ? {{35{dq[31]}}, dq} : {35'b0, dq};
    if (size == 2'b00) den = sg ? {{51{dv[15]}}, dv[15:0]} : {51'b0, dv[15:0]};
    else               den = sg ? {{35{dv[31]}}, dv} : {35'b0, dv};
    if (den == 0) begin
      e_dz = 1; e_n = nin; e_z = zin; e_v = vin;
      t_flag = "R2"; t_wr[0] = "R2"; t_wr[1] = "R2"; t_dat = "R2";
      m_left = 1;
    end else begin
      e_dz = 0;
      q = num / den;
      r = num % den;
      m_left = (size[1] ? 64 : 32) + 1;
      if (size == 2'b00)
        ovf = sg ? (q > 67'sd32767 || q < -67'sd32768) : (q > 67'sd65535);
      else
        ovf = sg ? (q > 67'sd2147483647 || q < -67'sd2147483648) : (q > 67'sd4294967295);
      if (ovf) begin
        e_v = 1; e_z = 0; e_n = nin;
        t_flag = (size == 2'b00) ? "R3" : (size[1] ? "R6" : "R4");
        t_wr[0] = "R4"; t_wr[1] = "R4"; t_dat = "R4";
      end else if (size == 2'b00) begin
        e_n = q[15]; e_z = (q[15:0] == 0); e_v = 0;
        e_qdat = {r[15:0], q[15:0]};
        e_qwe[0] = 1; e_qwe[1] = 1;
        t_flag = "R5"; t_wr[0] = "R5"; t_wr[1] = "R5"; t_dat = sg ? "R10" : "R5";
      end else begin
        e_n = q[31]; e_z = (q[31:0] == 0); e_v = 0;
        e_qdat = q[31:0]; e_rdat = r[31:0];
        e_qwe[0] = 1; e_rwe[0] = (qs != rs);
        t_wr[0] = "R7";
        if (size == 2'b01) begin
          e_qwe[1] = (qs == rs); e_rwe[1] = (qs != rs); t_wr[1] = "R8";
        end else begin
          e_qwe[1] = 1; e_rwe[1] = (qs != rs); t_wr[1] = "R7";
        end
        t_flag = "R9"; t_dat = sg ? "R10" : (size[1] ? "R6" : "R9");
      end
    end
  endtask

  always @(posedge clk) begin
    bit was_busy;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_done = 0;
    end else begin
      was_busy = m_busy;
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end
      if (start && !was_busy) begin
        model_start();
        m_busy = 1;
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        chk("R11", "busy", busy[i], m_busy);
        chk("R11", "done", done[i], m_done);
        if (m_done) begin
          chk("R2", "dz", dz[i], e_dz);
          chk("R1", "carry", fc[i], 0);
          chk(t_flag, "N", fn[i], e_n);
          chk(t_flag, "Z", fz[i], e_z);
          chk(t_flag, "V", fv[i], e_v);
          chk(t_wr[i], "qwe", qwe[i], e_qwe[i]);
          chk(t_wr[i], "rwe", rwe[i], e_rwe[i]);
          if (e_qwe[i]) begin
            chk(t_dat, "qsel", qso[i], e_qs);
            chk(t_dat, "qdat", qdat[i], e_qdat);
          end
          if (e_rwe[i]) begin
            chk(t_dat, "rsel", rso[i], e_rs);
            chk(t_dat, "rdat", rdat[i], e_rdat);
          end
        end
      end
    end
  end

  task automatic op(input logic [1:0] s, input logic g, input logic [31:0] a, input logic [31:0] h,
                    input logic [31:0] d, input logic [2:0] qi, input logic [2:0] ri, input bit poke);
    @(negedge clk);
    size = s; sg = g; dq = a; dr = h; dv = d; qs = qi; rs = ri;
    nin = 1'($urandom); zin = 1'($urandom); vin = 1'($urandom);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dq = $urandom; dr = $urandom; dv = $urandom; qs = 3'($urandom); rs = 3'($urandom);
    nin = 1'($urandom); zin = 1'($urandom); vin = 1'($urandom);
    size = 2'($urandom); sg = 1'($urandom);
    if (poke) begin
      // R11: a start while busy must be ignored
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk("R12", "busy", busy[i], 0);
      chk("R12", "done", done[i], 0);
      chk("R12", "qwe", qwe[i], 0);
      chk("R12", "rwe", rwe[i], 0);
    end
    rst_n = 1'b1;

    op(2'b00, 0, 32'd100, 0, 32'd7, 3'd2, 3'd5, 0);               // R5
    op(2'b00, 0, 32'h0001_0000, 0, 32'd1, 3'd1, 3'd1, 0);         // R3 unsigned overflow
    op(2'b00, 1, 32'hFFFF_FFF9, 0, 32'hABCD_0002, 3'd0, 3'd4, 0); // R10 -7/2
    op(2'b00, 1, 32'd7, 0, 32'h1234_FFFE, 3'd3, 3'd3, 0);         // R10 7/-2
    op(2'b00, 1, 32'h0000_8000, 0, 32'd1, 3'd3, 3'd0, 0);         // R3 signed overflow
    op(2'b00, 1, 32'hFFFF_8000, 0, 32'd1, 3'd3, 3'd0, 0);         // R3 boundary fits
    op(2'b00, 0, 32'd3, 0, 32'd5, 3'd6, 3'd1, 0);                 // R5 zero quotient
    op(2'b00, 0, 32'd3, 0, 32'h0001_0000, 3'd6, 3'd1, 0);         // R2 low half zero
    op(2'b01, 0, 32'd0, 0, 32'd0, 3'd6, 3'd1, 0);                 // R2
    op(2'b10, 1, 32'd9, 32'd9, 32'd0, 3'd6, 3'd6, 0);             // R2
    op(2'b01, 0, 32'hFFFF_FFFF, 0, 32'd10, 3'd2, 3'd2, 0);        // R7/R8 same regs
    op(2'b01, 0, 32'hFFFF_FFFF, 0, 32'd10, 3'd2, 3'd5, 0);        // R7/R8 different regs
    op(2'b01, 1, 32'h8000_0000, 0, 32'hFFFF_FFFF, 3'd2, 3'd5, 0); // R10 MIN/-1 overflow
    op(2'b01, 1, 32'hFFFF_FFF9, 0, 32'd2, 3'd2, 3'd5, 0);         // R10
    op(2'b10, 0, 32'h0, 32'h1, 32'd2, 3'd1, 3'd4, 0);             // R6 0x80000000
    op(2'b10, 0, 32'h0, 32'h5, 32'd5, 3'd1, 3'd4, 0);             // R6 overflow
    op(2'b11, 1, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 3'd1, 3'd4, 0); // R6 signed overflow
    op(2'b10, 1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0001_0000, 3'd7, 3'd7, 0); // R9 -65536
    op(2'b10, 0, 32'd5, 32'd0, 32'd10, 3'd0, 3'd1, 0);            // R9 zero quotient
    op(2'b00, 0, 32'd1000, 0, 32'd3, 3'd2, 3'd5, 1);              // R11 start while busy
    op(2'b10, 1, 32'd1000, 32'd0, 32'd3, 3'd2, 3'd5, 1);          // R11 start while busy

    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, h, d;
      logic [1:0] s;
      logic [2:0] qi, ri;
      s = 2'($urandom);
      a = $urandom; h = $urandom; d = $urandom;
      if (($urandom % 4) == 0) h = $urandom % 16;
      if (($urandom % 8) == 0) d = d & 32'hFFFF_0000;
      if (($urandom % 16) == 0) d = 0;
      qi = 3'($urandom);
      ri = (($urandom % 3) == 0) ? qi : 3'($urandom);
      op(s, 1'($urandom), a, h, d, qi, ri, ($urandom % 10) == 0);
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule